// File: doc/BRIEF.md
# Floating-point control and status register

This block is the control/status register that sits next to a floating-point datapath. It stores a two-bit rounding-mode field and two five-bit groups of IEEE exception flags. The current group describes only the most recent operation. The accrued group is sticky and collects every flag raised since software last cleared it. Software reaches the register through a simple single-cycle port, and the datapath sends one exception report per completed operation. The rounding mode is driven back to the datapath at all times.

An enable input decides whether floating-point state may be touched. While the enable is low, no software access and no exception report changes the register. Any such attempt raises a disabled-trap output in the same cycle, which the surrounding pipeline turns into an exception. Reserved bits are never stored: they read as zero whatever is written to them.

Top module: `fcsr_unit`

## Requirements
- R1: After reset the stored value is all zeros. That means round-to-nearest-even with no flags set, so `rd_data` and `rnd_mode` read zero.
- R2: A software write (`sw_req`=1, `sw_we`=1, `fp_en`=1) stores bits 11:0 of `sw_wdata` at the next clock edge. Bits 31:12 always read as zero.
- R3: `rnd_mode` always equals stored bits 11:10, with these encodings: 0 round to nearest even, 1 round toward zero, 2 round up, 3 round down.
- R4: An accepted exception report (`exc_valid`=1 with `fp_en`=1 and no write in the same cycle) replaces current bits 4:0 with `exc_flags` at the next edge. The flag order is bit 4 invalid, bit 3 overflow, bit 2 underflow, bit 1 divide-by-zero and bit 0 inexact.
- R5: An accepted report ORs `exc_flags` into accrued bits 9:5, using the same bit order. No accrued bit is ever cleared by a report.
- R6: An accepted report with all-zero flags clears the current group and leaves the accrued group and the rounding mode unchanged.
- R7: When a software write and an exception report arrive in the same enabled cycle, the write alone determines the new value and the report is dropped.
- R8: While `fp_en`=0, a software access or an exception report leaves the stored value unchanged and raises `fp_trap` in that same cycle.
- R9: `fp_trap` is low whenever `fp_en`=1, and it is low when there is no access and no report.
- R10: `rd_data` is combinational. It shows the stored value while `fp_en`=1 and reads zero while `fp_en`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| fp_en | input | 1 | Floating-point state access enable |
| sw_req | input | 1 | Software access strobe |
| sw_we | input | 1 | Software access is a write |
| sw_wdata | input | 32 | Software write data |
| exc_valid | input | 1 | Exception report from datapath |
| exc_flags | input | 5 | Reported flags (invalid, overflow, underflow, div-by-zero, inexact) |
| rd_data | output | 32 | Register read value |
| rnd_mode | output | 2 | Rounding mode to the datapath |
| fp_trap | output | 1 | Floating-point disabled trap |

## Verification
The properties assume that every input is a known value at each sampled edge and that `exc_flags` is meaningful only when `exc_valid` is high. They place no other limit on how the strobes combine: a write, a read and a report may all arrive in the same cycle, with the enable either high or low. The bench drives its inputs on the falling edge and holds them through the next rising edge. Between vectors it returns to an enabled idle cycle, so the stored value can be read back at the ports without disturbing it.

// File: rtl/fcsr_pkg.sv
package fcsr_pkg;
  localparam int CSR_W   = 32;
  localparam int FLAG_W  = 5;
  localparam int RM_W    = 2;
  localparam int CUR_LSB = 0;
  localparam int ACC_LSB = CUR_LSB + FLAG_W;
  localparam int RM_LSB  = ACC_LSB + FLAG_W;
  localparam int LIVE_W  = RM_LSB + RM_W;

  typedef logic [CSR_W-1:0]  csr_t;
  typedef logic [FLAG_W-1:0] flags_t;
  typedef logic [RM_W-1:0]   rm_t;

  function automatic csr_t live_mask();
    return {{(CSR_W-LIVE_W){1'b0}}, {LIVE_W{1'b1}}};
  endfunction

  function automatic csr_t scrub(csr_t w);
    return w & live_mask();
  endfunction

  function automatic rm_t get_rm(csr_t v);
    return v[RM_LSB +: RM_W];
  endfunction

  // current group replaced, accrued group merged
  function automatic csr_t fold_report(csr_t v, flags_t f);
    csr_t r;
    r = v;
    r[CUR_LSB +: FLAG_W] = f;
    r[ACC_LSB +: FLAG_W] = v[ACC_LSB +: FLAG_W] | f;
    return r;
  endfunction
endpackage

// File: rtl/fcsr_gate.sv
module fcsr_gate (
  input  logic fp_en,
  input  logic sw_req,
  input  logic sw_we,
  input  logic exc_valid,
  output logic wr_ok,
  output logic rep_ok,
  output logic trap
);
  always_comb begin
    wr_ok  = fp_en & sw_req & sw_we;
    rep_ok = fp_en & exc_valid & ~wr_ok;   // write has priority
    trap   = ~fp_en & (sw_req | exc_valid);
  end
endmodule

// File: rtl/fcsr_next.sv
module fcsr_next
  import fcsr_pkg::*;
(
  input  csr_t   cur,
  input  logic   wr_ok,
  input  csr_t   wdata,
  input  logic   rep_ok,
  input  flags_t flags,
  output csr_t   nxt
);
  always_comb begin
    nxt = cur;
    if (wr_ok)       nxt = scrub(wdata);
    else if (rep_ok) nxt = fold_report(cur, flags);
  end
endmodule

// File: rtl/fcsr_view.sv
module fcsr_view
  import fcsr_pkg::*;
(
  input  csr_t cur,
  input  logic fp_en,
  output csr_t rdata,
  output rm_t  rm
);
  always_comb begin
    rdata = fp_en ? cur : '0;
    rm    = get_rm(cur);
  end
endmodule

// File: rtl/fcsr_unit.sv
module fcsr_unit
  import fcsr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fp_en,
  input  logic              sw_req,
  input  logic              sw_we,
  input  logic [CSR_W-1:0]  sw_wdata,
  input  logic              exc_valid,
  input  logic [FLAG_W-1:0] exc_flags,
  output logic [CSR_W-1:0]  rd_data,
  output logic [RM_W-1:0]   rnd_mode,
  output logic              fp_trap
);
  csr_t csr_q;
  csr_t csr_d;
  logic wr_ok;
  logic rep_ok;

  fcsr_gate u_gate (
    .fp_en     (fp_en),
    .sw_req    (sw_req),
    .sw_we     (sw_we),
    .exc_valid (exc_valid),
    .wr_ok     (wr_ok),
    .rep_ok    (rep_ok),
    .trap      (fp_trap)
  );

  fcsr_next u_next (
    .cur    (csr_q),
    .wr_ok  (wr_ok),
    .wdata  (sw_wdata),
    .rep_ok (rep_ok),
    .flags  (exc_flags),
    .nxt    (csr_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) csr_q <= '0;
    else        csr_q <= csr_d;
  end

  fcsr_view u_view (
    .cur   (csr_q),
    .fp_en (fp_en),
    .rdata (rd_data),
    .rm    (rnd_mode)
  );
endmodule

// File: rtl/fcsr_unit_chk.sv
module fcsr_unit_chk
  import fcsr_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              fp_en,
  input logic              sw_req,
  input logic              sw_we,
  input logic [CSR_W-1:0]  sw_wdata,
  input logic              exc_valid,
  input logic [FLAG_W-1:0] exc_flags,
  input logic [CSR_W-1:0]  rd_data,
  input logic [RM_W-1:0]   rnd_mode,
  input logic              fp_trap,
  input logic [CSR_W-1:0]  csr_q
);
  logic wr_seen;
  logic rep_seen;
  assign wr_seen  = fp_en && sw_req && sw_we;
  assign rep_seen = fp_en && exc_valid && !wr_seen;

  p_reserved_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[CSR_W-1:LIVE_W] == '0);

  p_rm_export_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fp_en |-> rnd_mode == rd_data[RM_LSB +: RM_W]);

  p_cur_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rep_seen |=> csr_q[CUR_LSB +: FLAG_W] == $past(exc_flags));

  p_acc_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rep_seen |=> ((csr_q[ACC_LSB +: FLAG_W] & $past(csr_q[ACC_LSB +: FLAG_W]))
                  == $past(csr_q[ACC_LSB +: FLAG_W])));

  p_acc_gets_flags_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rep_seen |=> ((csr_q[ACC_LSB +: FLAG_W] & $past(exc_flags)) == $past(exc_flags)));

  p_rm_kept_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rep_seen |=> $stable(rnd_mode));

  p_write_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_seen |=> csr_q == ($past(sw_wdata) & live_mask()));

  p_disabled_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !fp_en |=> $stable(csr_q));

  p_disabled_trap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!fp_en && (sw_req || exc_valid)) |-> fp_trap);

  p_trap_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (fp_en || (!sw_req && !exc_valid)) |-> !fp_trap);

  p_rdata_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !fp_en |-> rd_data == '0);
endmodule

bind fcsr_unit fcsr_unit_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .fp_en     (fp_en),
  .sw_req    (sw_req),
  .sw_we     (sw_we),
  .sw_wdata  (sw_wdata),
  .exc_valid (exc_valid),
  .exc_flags (exc_flags),
  .rd_data   (rd_data),
  .rnd_mode  (rnd_mode),
  .fp_trap   (fp_trap),
  .csr_q     (csr_q)
);

// File: tb/tb_fcsr_unit.sv
module tb_fcsr_unit;
  localparam int CLK_P = 10;
  localparam int NV    = 10;

  typedef struct packed {
    logic        en;
    logic        req;
    logic        we;
    logic [31:0] wd;
    logic        ev;
    logic [4:0]  fl;
    logic        trap;
    logic [31:0] exp;
  } vec_t;

  // en req we wdata ev flags trap expected-stored
  localparam vec_t VECS [NV] = '{
    '{1'b1, 1'b1, 1'b1, 32'hFFFF_F000, 1'b0, 5'b00000, 1'b0, 32'h0000_0000}, // R2
    '{1'b1, 1'b1, 1'b1, 32'h0000_0800, 1'b0, 5'b00000, 1'b0, 32'h0000_0800}, // R3 round up
    '{1'b1, 1'b0, 1'b0, 32'h0000_0000, 1'b1, 5'b00101, 1'b0, 32'h0000_08A5}, // R4 R5
    '{1'b1, 1'b0, 1'b0, 32'h0000_0000, 1'b1, 5'b01000, 1'b0, 32'h0000_09A8}, // R5
    '{1'b1, 1'b0, 1'b0, 32'h0000_0000, 1'b1, 5'b00000, 1'b0, 32'h0000_09A0}, // R6
    '{1'b0, 1'b1, 1'b1, 32'h0000_03FF, 1'b0, 5'b00000, 1'b1, 32'h0000_09A0}, // R8 write
    '{1'b0, 1'b0, 1'b0, 32'h0000_0000, 1'b1, 5'b10000, 1'b1, 32'h0000_09A0}, // R8 report
    '{1'b1, 1'b1, 1'b1, 32'h0000_0C1F, 1'b1, 5'b10000, 1'b0, 32'h0000_0C1F}, // R7
    '{1'b1, 1'b1, 1'b0, 32'hDEAD_BEEF, 1'b0, 5'b00000, 1'b0, 32'h0000_0C1F}, // R10 read
    '{1'b1, 1'b0, 1'b0, 32'h0000_0000, 1'b1, 5'b10000, 1'b0, 32'h0000_0E10}  // R4
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fp_en = 1'b0;
  logic        sw_req = 1'b0;
  logic        sw_we = 1'b0;
  logic [31:0] sw_wdata = '0;
  logic        exc_valid = 1'b0;
  logic [4:0]  exc_flags = '0;
  logic [31:0] rd_data;
  logic [1:0]  rnd_mode;
  logic        fp_trap;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  fcsr_unit dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .fp_en     (fp_en),
    .sw_req    (sw_req),
    .sw_we     (sw_we),
    .sw_wdata  (sw_wdata),
    .exc_valid (exc_valid),
    .exc_flags (exc_flags),
    .rd_data   (rd_data),
    .rnd_mode  (rnd_mode),
    .fp_trap   (fp_trap)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(logic en, logic rq, logic we, logic [31:0] wd,
                       logic ev, logic [4:0] fl);
    fp_en = en; sw_req = rq; sw_we = we; sw_wdata = wd;
    exc_valid = ev; exc_flags = fl;
  endtask

  task automatic idle_read(string req, logic [31:0] exp);
    @(negedge clk);
    drive(1'b1, 1'b0, 1'b0, '0, 1'b0, '0);
    #1;
    chk(req, rd_data, exp);
    chk("R3 rnd_mode", {30'd0, rnd_mode}, {30'd0, exp[11:10]});
    chk("R9 trap idle", {31'd0, fp_trap}, 32'd0);
  endtask

  initial begin
    #(CLK_P * 20000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    drive(1'b1, 1'b0, 1'b0, '0, 1'b0, '0);
    #1;
    chk("R1 rdata in reset", rd_data, 32'd0);
    rst_n = 1'b1;
    idle_read("R1 after reset", 32'd0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(VECS[i].en, VECS[i].req, VECS[i].we, VECS[i].wd, VECS[i].ev, VECS[i].fl);
      #1;
      chk("R8/R9 trap", {31'd0, fp_trap}, {31'd0, VECS[i].trap});
      idle_read("R2-R10 stored value", VECS[i].exp);
    end

    // R10: disabled read returns zero; R9 no trap without access
    @(negedge clk);
    drive(1'b0, 1'b0, 1'b0, '0, 1'b0, '0);
    #1;
    chk("R10 disabled rdata", rd_data, 32'd0);
    chk("R9 disabled idle trap", {31'd0, fp_trap}, 32'd0);
    chk("R3 rnd_mode while disabled", {30'd0, rnd_mode}, 32'd3);

    // R3: each rounding encoding
    for (int m = 0; m < 4; m++) begin
      @(negedge clk);
      drive(1'b1, 1'b1, 1'b1, 32'(m) << 10, 1'b0, '0);
      idle_read("R3 encoding", 32'(m) << 10);
    end

    // R5: accrued saturates to all ones and stays
    @(negedge clk);
    drive(1'b1, 1'b0, 1'b0, '0, 1'b1, 5'b11111);
    idle_read("R5 all flags", 32'h0000_0FFF);
    @(negedge clk);
    drive(1'b1, 1'b0, 1'b0, '0, 1'b1, 5'b00010);
    idle_read("R5 sticky", 32'h0000_0FE2);

    // R1: reset mid-run
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R1 async reset", rd_data, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    idle_read("R1 after second reset", 32'd0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule